// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block gathers interrupt requests from five peripheral sources on behalf of a small 8-bit processor core. Each source pulses its request line for one cycle, and the pulse latches a bit in a pending-flag register. A second register holds a per-source mask. Software reaches both registers as bytes on a memory-mapped bus. A global master-enable bit is switched on and off by strobes that the core raises when it decodes its interrupt enable and disable instructions.

Each cycle the controller ANDs the flags with the mask and looks for the lowest-numbered set bit. It drives three outputs toward the core: a wake signal that ignores the master enable, a request that needs the master enable, and the 16-bit entry address of the winning source. When the core acknowledges a request, the controller clears that source's flag and turns the master enable off. The core then saves its PC and jumps to the entry address; that part is outside this block.

Top module: `irq_ctrl`

## Requirements
- R1: While rst_ni is low, the flag register, the mask register and the master enable are all cleared, and wake_o and irq_req_o are 0.
- R2: A one-cycle pulse on src_req_i[i] sets flag bit i on the next clock edge. Bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is joypad. If a set and a clear hit the same bit in the same cycle, the set wins, whether the clear comes from a bus write or from an acknowledge.
- R3: A bus write to address 0xFF0F loads bus_wdata_i[4:0] into the flag register. A bus write to 0xFFFF loads bus_wdata_i[4:0] into the mask register. Bits 7:5 of the written data are ignored.
- R4: bus_rdata_o is combinational from bus_addr_i. It returns {3'b111, flags} at 0xFF0F, {3'b111, mask} at 0xFFFF, and 0x00 at any other address.
- R5: wake_o is 1 exactly when some flag bit and the matching mask bit are both set. The master enable has no effect on it.
- R6: irq_req_o is 1 exactly when the master enable is set and wake_o is 1. irq_vec_o is 0x0040 + 8*i for the chosen source i while irq_req_o is 1, and 0x0000 otherwise.
- R7: If several sources are pending and unmasked, the lowest bit number is chosen.
- R8: ime_set_i sets the master enable and ime_clr_i clears it. If both are high in the same cycle, the clear wins.
- R9: When irq_ack_i is high at a clock edge while irq_req_o is high, the next cycle shows the chosen flag bit cleared and the master enable cleared. Both clears override a same-cycle ime_set_i. An acknowledge while irq_req_o is low changes nothing.
- R10: A flag whose mask bit is clear, or that is pending while the master enable is clear, stays set until it is acknowledged or written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 5 | One-cycle request pulses, one per source |
| bus_addr_i | input | 16 | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data |
| ime_set_i | input | 1 | Master-enable set strobe |
| ime_clr_i | input | 1 | Master-enable clear strobe |
| irq_ack_i | input | 1 | Core accepts the current request |
| irq_req_o | output | 1 | Vectoring request to the core |
| irq_vec_o | output | 16 | Entry address of the chosen source |
| wake_o | output | 1 | Leave halt; independent of the master enable |

## Verification
Some properties are checked by assertions on every cycle. A grant is always one-hot and always the lowest pending bit. An issued vector is aligned and within the entry table. A request always implies wake. An accepted acknowledge drops the request in the next cycle. A set always lands, and an untouched flag never drops by itself. Other behaviour can only be shown by the bench scenarios, which compare every cycle against a reference model. These are the mapping from source to entry address and the set-beats-clear order when it interacts with a bus write. They also cover the 1s read back in the unused bits, the decode of other addresses, and an acknowledge that has no effect when irq_req_o is low. A flag kept pending through long stretches with its mask bit or the master enable clear is covered the same way.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC    = 5;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned VEC_BASE   = 'h0040;
  localparam int unsigned VEC_STRIDE = 8;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 16'hFFFF;
endpackage

// File: rtl/irq_bit_bank.sv
module irq_bit_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_data_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] bits_o
);
  logic [N-1:0] bits_q;

  // per bit: set > clear > write
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          bits_q[i] <= 1'b0;
      else if (set_i[i])    bits_q[i] <= 1'b1;
      else if (clr_i[i])    bits_q[i] <= 1'b0;
      else if (wr_en_i)     bits_q[i] <= wr_data_i[i];
    end
  end

  assign bits_o = bits_q;

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i))); // R2

  AST_BIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && clr_i == '0) |=> ((bits_q & $past(bits_q)) == $past(bits_q))); // R10
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 5,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pend_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |pend_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o != '0) == (pend_i != '0))); // R7

  AST_GRANT_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> ((((grant_o - 1'b1) & pend_i) == '0) && ((grant_o & pend_i) == grant_o))); // R7
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned V_BASE = VEC_BASE,
  parameter int unsigned V_STEP = VEC_STRIDE,
  parameter logic [AW-1:0] F_ADDR = FLAG_ADDR,
  parameter logic [AW-1:0] M_ADDR = MASK_ADDR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             ime_set_i,
  input  logic             ime_clr_i,
  input  logic             irq_ack_i,
  output logic             irq_req_o,
  output logic [AW-1:0]    irq_vec_o,
  output logic             wake_o
);
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned PAD_W   = DW - N_SRC;
  localparam int unsigned V_LAST  = V_BASE + (N_SRC - 1) * V_STEP;

  logic [N_SRC-1:0] flag_q, mask_q, pend, grant, ack_clr;
  logic [IDX_W-1:0] idx;
  logic             any_pend, ime_q, take;
  logic             wr_flag, wr_mask;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DW-1:N_SRC];

  assign wr_flag = bus_wr_i && (bus_addr_i == F_ADDR);
  assign wr_mask = bus_wr_i && (bus_addr_i == M_ADDR);
  assign take    = irq_ack_i && irq_req_o;
  assign ack_clr = take ? grant : '0;

  irq_bit_bank #(.N(N_SRC)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_flag),
    .wr_data_i (bus_wdata_i[N_SRC-1:0]),
    .clr_i     (ack_clr),
    .set_i     (src_req_i),
    .bits_o    (flag_q)
  );

  irq_bit_bank #(.N(N_SRC)) i_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_mask),
    .wr_data_i (bus_wdata_i[N_SRC-1:0]),
    .clr_i     ('0),
    .set_i     ('0),
    .bits_o    (mask_q)
  );

  assign pend = flag_q & mask_q;

  irq_prio_pick #(.N(N_SRC)) i_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .grant_o (grant),
    .idx_o   (idx),
    .any_o   (any_pend)
  );

  // master enable: service and disable beat enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ime_q <= 1'b0;
    else if (take || ime_clr_i) ime_q <= 1'b0;
    else if (ime_set_i)         ime_q <= 1'b1;
  end

  assign wake_o    = any_pend;
  assign irq_req_o = ime_q && any_pend;
  assign irq_vec_o = irq_req_o ? AW'(V_BASE + int'(idx) * V_STEP) : '0;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == F_ADDR)      bus_rdata_o = {{PAD_W{1'b1}}, flag_q};
    else if (bus_addr_i == M_ADDR) bus_rdata_o = {{PAD_W{1'b1}}, mask_q};
  end

  AST_REQ_NEEDS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> wake_o); // R6

  AST_VEC_IN_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o >= AW'(V_BASE) && irq_vec_o <= AW'(V_LAST) && irq_vec_o[2:0] == 3'b000)); // R6

  AST_ACK_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !irq_req_o); // R9

  AST_IME_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ime_set_i && !ime_clr_i && !take && any_pend && (flag_q & mask_q) != '0 && !wr_flag && !wr_mask)
      |=> irq_req_o); // R8
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam int CLK_P = 10;
  localparam logic [15:0] FA = 16'hFF0F;
  localparam logic [15:0] MA = 16'hFFFF;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]  src_req_i = '0;
  logic [15:0] bus_addr_i = FA;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        ime_set_i = 1'b0, ime_clr_i = 1'b0, irq_ack_i = 1'b0;
  logic        irq_req_o, wake_o;
  logic [15:0] irq_vec_o;

  int total = 0, bad = 0;
  logic [4:0] m_flag = '0, m_mask = '0;
  logic       m_ime = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  irq_ctrl i_irq_ctrl (
    .clk_i, .rst_ni, .src_req_i, .bus_addr_i, .bus_wr_i, .bus_wdata_i, .bus_rdata_o,
    .ime_set_i, .ime_clr_i, .irq_ack_i, .irq_req_o, .irq_vec_o, .wake_o
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [4:0] p, input logic ime);
    for (int i = 4; i >= 0; i--) if (p[i] && ime) exp_vec = 16'h0040 + 16'(i * 8);
    if (!(ime && p != 0)) exp_vec = 16'h0000;
  endfunction

  function automatic logic [4:0] lowest(input logic [4:0] p);
    lowest = '0;
    for (int i = 4; i >= 0; i--) if (p[i]) lowest = 5'(1 << i);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (a == FA)      exp_rd = {3'b111, m_flag};
    else if (a == MA) exp_rd = {3'b111, m_mask};
    else              exp_rd = 8'h00;
  endfunction

  // drive after negedge, check combinational outputs, advance the model
  task automatic cyc(input logic [4:0] src, input logic wr, input logic [15:0] a,
                     input logic [7:0] wd, input logic es, input logic ec, input logic ak);
    logic [4:0] p;
    logic       rq;
    @(negedge clk_i);
    src_req_i = src; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
    ime_set_i = es; ime_clr_i = ec; irq_ack_i = ak;
    #1;
    p  = m_flag & m_mask;
    rq = m_ime && (p != 0);
    chk("R5 wake", 16'(wake_o), 16'(p != 0));
    chk("R6 req", 16'(irq_req_o), 16'(rq));
    chk("R7 R6 vector", irq_vec_o, exp_vec(p, m_ime));
    chk("R4 R3 R10 readback", 16'(bus_rdata_o), 16'(exp_rd(a)));
    if (wr && a == FA) m_flag = wd[4:0];
    if (wr && a == MA) m_mask = wd[4:0];
    if (ak && rq) m_flag = m_flag & ~lowest(p);
    m_flag = m_flag | src;
    if ((ak && rq) || ec) m_ime = 1'b0;
    else if (es)          m_ime = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk("R1 wake in reset", 16'(wake_o), 16'h0);
    chk("R1 req in reset", 16'(irq_req_o), 16'h0);
    chk("R1 flag read", 16'(bus_rdata_o), 16'h00E0);
    bus_addr_i = MA; #1;
    chk("R1 mask read", 16'(bus_rdata_o), 16'h00E0);
    rst_ni = 1'b1;

    // R10 R5: pending with ime off wakes but does not vector
    cyc(5'b10110, 1'b0, FA, 8'h00, 0, 0, 0);
    cyc(5'b00000, 1'b1, MA, 8'h1F, 0, 0, 0);
    cyc(5'b00000, 1'b0, FA, 8'h00, 0, 0, 1);   // R9 ack without req is ignored
    cyc(5'b00000, 1'b0, FA, 8'h00, 1, 0, 0);   // R8 set ime
    // R7 status (bit1) wins -> 0x0048, R9 ack clears bit1 and ime despite set
    cyc(5'b00000, 1'b0, FA, 8'h00, 1, 0, 1);
    cyc(5'b00000, 1'b0, FA, 8'h00, 0, 0, 0);
    chk("R9 ime dropped after ack", 16'(irq_req_o), 16'h0);
    // R8 set and clear together: clear wins
    cyc(5'b00000, 1'b0, FA, 8'h00, 1, 1, 0);
    // R2 set beats a bus write of zero
    cyc(5'b01000, 1'b1, FA, 8'h00, 0, 0, 0);
    cyc(5'b00000, 1'b0, FA, 8'h00, 0, 0, 0);
    chk("R2 set beats write clear", 16'(bus_rdata_o), 16'h00E8);
    // R3 unused bits ignored on write, read back as 1
    cyc(5'b00000, 1'b1, MA, 8'hE0, 0, 0, 0);
    cyc(5'b00000, 1'b1, FA, 8'h1F, 1, 0, 0);
    cyc(5'b00000, 1'b0, MA, 8'h00, 0, 0, 0);
    chk("R3 mask write ignores high bits", 16'(bus_rdata_o), 16'h00E0);
    chk("R10 masked flags hold, no wake", 16'(wake_o), 16'h0);
    // R7 joypad alone, then R2 set beats ack clear on the same bit
    cyc(5'b00000, 1'b1, FA, 8'h10, 0, 0, 0);
    cyc(5'b00000, 1'b1, MA, 8'h10, 0, 0, 0);
    cyc(5'b10000, 1'b0, FA, 8'h00, 0, 0, 1);
    cyc(5'b00000, 1'b0, 16'h1234, 8'h00, 0, 0, 0);  // R4 other address reads 0
    cyc(5'b00000, 1'b0, FA, 8'h00, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]  s;
      logic [15:0] a;
      logic        w;
      s = 5'(($urandom % 8 == 0) ? (1 << ($urandom % 5)) : 0);
      if ($urandom % 16 == 0) s = 5'($urandom);
      case ($urandom % 4)
        0: a = FA; 1: a = MA; 2: a = FA; default: a = 16'($urandom);
      endcase
      w = ($urandom % 10 == 0);
      cyc(s, w, a, 8'($urandom), ($urandom % 6 == 0), ($urandom % 12 == 0), ($urandom % 3 == 0));
    end

    // R1 asynchronous reset mid-run
    @(negedge clk_i); rst_ni = 1'b0; #1;
    m_flag = '0; m_mask = '0; m_ime = 1'b0;
    chk("R1 wake after reset", 16'(wake_o), 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule